// File: doc/BRIEF.md
# Clock frequency monitor unit

This block watches the frequency of two clocks from the point of view of a trusted reference clock. Software writes a window length, in reference cycles, and sets a start bit. During the window the block counts rising edges of a monitored clock and of a second oscillator clock. At the end of the window the monitored count goes to a read-only display register. It is compared against an upper and a lower limit. The second count is compared against a minimum limit only. Each violation sets a sticky status flag. A flag drives the interrupt output only when its enable bit is set.

A period mode measures an internal oscillator for trimming. In this mode the window is a number of internal-oscillator rising edges, and the display shows how many reference cycles those edges took. No limit comparison runs in this mode.

The control register can be locked against writes. A soft lock can be released by software. A hard lock holds until reset. All other registers stay writable while the lock is set. Both monitored clocks and the internal oscillator are sampled in the reference domain through two-flop synchronizers, so each must run below half the reference frequency.

Top module: `clkmon_unit`

## Requirements
- R1: After reset every register reads zero, both the range check and the minimum check are disabled, and irq is low.
- R2: Writing 1 to control bit 0 starts a measurement that lasts the number of reference cycles in the duration register at 0x18 (a value of 0 acts as 1). Control bit 0 reads 1 while the measurement runs. When the window closes, the display register at 0x04 holds the number of monitored-clock rising edges seen in the window.
- R3: With control bit 1 set, a final count above the high limit (0x08) sets status bit 0, and a final count below the low limit (0x0C) sets status bit 1. With control bit 1 clear, neither flag is set.
- R4: With control bit 2 set, an oscillator-clock count below control field [31:16] sets status bit 2.
- R5: With control bit 3 set, the window ends on the duration-register-th rising edge of the internal oscillator. The display then shows the reference cycles elapsed, and no status flag is set.
- R6: irq is high exactly when a status bit is set whose enable is also set. Control bits 4, 5 and 6 enable status bits 0, 1 and 2.
- R7: Status flags at 0x10 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: Writes to the reserved offset 0x14 and to the display register 0x04 have no effect, and 0x14 reads zero.
- R9: Writing control bit 8 = 1 with bit 9 = 0 sets a soft lock. While the soft lock is set, control writes change only bits 9:8, and writing bit 8 = 0 releases the lock. Registers other than control stay writable.
- R10: Writing control bits 9:8 = 11 sets a hard lock. While it is set, every control write is dropped, including a start request, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_clk | input | 1 | Monitored clock for the range check |
| osc_clk | input | 1 | Oscillator clock for the minimum check |
| irc_clk | input | 1 | Internal oscillator measured in period mode |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that writes are single-cycle strobes with a stable address and data, and that the three sampled clocks toggle slowly enough for the synchronizers to catch every edge. The bench drives every register input on the falling edge of the 4 ns reference clock. It runs the three sampled clocks at 16, 24 and 20 ns periods, which keeps each below half the reference rate. The measured counts vary by one edge with phase, so the bench checks each count against a window and sets the limits well clear of that window. This keeps the expected flags certain.

// File: rtl/clkmon_unit.sv
module clkmon_unit #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pll_clk,
  input  logic        osc_clk,
  input  logic        irc_clk,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam logic [4:0] A_CSR = 5'h00, A_FDR = 5'h04, A_HI = 5'h08,
                         A_LO  = 5'h0C, A_ISR = 5'h10, A_DUR = 5'h18;

  logic [2:0] s_pll, s_osc, s_irc;
  logic busy, range_en, min_en, per_mode, lock, hard;
  logic [2:0] ie, isr;
  logic [CW-1:0] min_lim, hi, lo, dur, fdr, win, cnt_a, cnt_b;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v, input logic inc);
    return (inc && v != '1) ? v + CW'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_pll <= '0; s_osc <= '0; s_irc <= '0;
    end else begin
      s_pll <= {s_pll[1:0], pll_clk};
      s_osc <= {s_osc[1:0], osc_clk};
      s_irc <= {s_irc[1:0], irc_clk};
    end

  wire pll_rise = s_pll[1] & ~s_pll[2];
  wire osc_rise = s_osc[1] & ~s_osc[2];
  wire irc_rise = s_irc[1] & ~s_irc[2];

  wire [CW-1:0] a_nx = per_mode ? bump(cnt_a, 1'b1) : bump(cnt_a, pll_rise);
  wire [CW-1:0] b_nx = bump(cnt_b, osc_rise);
  wire [CW-1:0] w_nx = per_mode ? bump(win, irc_rise) : bump(win, 1'b1);
  wire [CW-1:0] lim  = (dur == '0) ? CW'(1) : dur;
  wire fin   = busy && (w_nx >= lim);
  wire cmp   = fin && !per_mode;

  wire wr_csr = wr_en && addr == A_CSR;
  wire start  = wr_csr && !lock && wdata[0] && !busy;
  wire [2:0] set_f = {cmp && min_en && (b_nx < min_lim),
                      cmp && range_en && (a_nx < lo),
                      cmp && range_en && (a_nx > hi)};
  wire [2:0] clr_f = (wr_en && addr == A_ISR) ? wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; win <= '0; cnt_a <= '0; cnt_b <= '0; fdr <= '0;
    end else if (start) begin
      busy <= 1'b1; win <= '0; cnt_a <= '0; cnt_b <= '0;
    end else if (busy) begin
      win <= w_nx; cnt_a <= a_nx; cnt_b <= b_nx;
      if (fin) begin
        busy <= 1'b0;
        fdr  <= a_nx;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~clr_f) | set_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      range_en <= 1'b0; min_en <= 1'b0; per_mode <= 1'b0; ie <= '0;
      min_lim <= '0; lock <= 1'b0; hard <= 1'b0;
    end else if (wr_csr && !hard) begin
      if (!lock) begin
        range_en <= wdata[1];
        min_en   <= wdata[2];
        per_mode <= wdata[3];
        ie       <= wdata[6:4];
        min_lim  <= wdata[16 +: CW];
      end
      lock <= wdata[8];
      hard <= wdata[8] & wdata[9];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi <= '0; lo <= '0; dur <= '0;
    end else if (wr_en) begin
      if (addr == A_HI)  hi  <= wdata[CW-1:0];
      if (addr == A_LO)  lo  <= wdata[CW-1:0];
      if (addr == A_DUR) dur <= wdata[CW-1:0];
    end

  always_comb
    case (addr)
      A_CSR:   rdata = {16'(min_lim), 6'b0, hard, lock, 1'b0, ie, per_mode, min_en, range_en, busy};
      A_FDR:   rdata = 32'(fdr);
      A_HI:    rdata = 32'(hi);
      A_LO:    rdata = 32'(lo);
      A_ISR:   rdata = {29'b0, isr};
      A_DUR:   rdata = 32'(dur);
      default: rdata = '0;
    endcase

  assign irq = |(isr & ie);
endmodule

// File: rtl/clkmon_unit_chk.sv
module clkmon_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  addr,
  input logic [31:0] wdata,
  input logic        busy,
  input logic        range_en,
  input logic        min_en,
  input logic        per_mode,
  input logic        lock,
  input logic        hard,
  input logic [2:0]  ie,
  input logic [2:0]  isr,
  input logic        irq
);
  wire isr_wr = wr_en && addr == 5'h10;

  assert_hard_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && hard) |=> (lock && hard));

  assert_hard_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && hard) |=> $stable({range_en, min_en, per_mode, ie}));

  assert_no_start_hard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && hard && !busy) |=> !busy);

  assert_sticky_over_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[0] && !(isr_wr && wdata[0])) |=> isr[0]);

  assert_sticky_under_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[1] && !(isr_wr && wdata[1])) |=> isr[1]);

  assert_sticky_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[2] && !(isr_wr && wdata[2])) |=> isr[2]);

  assert_over_needs_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr[0]) |-> ($past(range_en) && $past(busy) && !$past(per_mode)));

  assert_low_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr[2]) |-> ($past(min_en) && $past(busy) && !$past(per_mode)));

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isr == 3'b000) |-> !irq);
endmodule

bind clkmon_unit clkmon_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .range_en(range_en), .min_en(min_en), .per_mode(per_mode),
  .lock(lock), .hard(hard), .ie(ie), .isr(isr), .irq(irq)
);

// File: tb/clkmon_unit_tb.sv
module clkmon_unit_tb;
  logic clk = 0, rst_n = 0, pll_clk = 0, osc_clk = 0, irc_clk = 0;
  logic wr_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  clkmon_unit u_dut (.clk(clk), .rst_n(rst_n), .pll_clk(pll_clk), .osc_clk(osc_clk),
    .irc_clk(irc_clk), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2  clk = ~clk;
  always #8  pll_clk = ~pll_clk;
  always #12 osc_clk = ~osc_clk;
  always #10 irc_clk = ~irc_clk;

  typedef struct { string req; int lo; int hi; logic [2:0] isr; } exp_t;
  exp_t q[$];
  event done_ev, ack_ev;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string req);
    logic [31:0] d;
    rd(a, d);
    check(d == e, req, d, e);
  endtask

  task automatic measure(input logic [31:0] ctrl, input string req,
                         input int lo, input int hi, input logic [2:0] isr_e);
    logic [31:0] d;
    wr(5'h10, 32'h7);
    q.push_back('{req, lo, hi, isr_e});
    wr(5'h00, ctrl | 32'h1);
    rd(5'h00, d);
    check(d[0] == 1'b1, {req, " busy"}, d[0], 1);
    for (int i = 0; i < 5000 && d[0]; i++) rd(5'h00, d);
    ->done_ev;
    @(ack_ev);
  endtask

  initial forever begin
    logic [31:0] f, s;
    exp_t e;
    @(done_ev);
    e = q.pop_front();
    rd(5'h04, f);
    rd(5'h10, s);
    check(int'(f) >= e.lo && int'(f) <= e.hi, {e.req, " display"}, f, e.lo);
    check(s[2:0] == e.isr, {e.req, " status"}, s[2:0], e.isr);
    ->ack_ev;
  end

  initial begin
    logic [31:0] d, keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(5'h00, 0, "R1 control");
    rd_chk(5'h04, 0, "R1 display");
    rd_chk(5'h08, 0, "R1 high");
    rd_chk(5'h0C, 0, "R1 low");
    rd_chk(5'h10, 0, "R1 status");
    rd_chk(5'h18, 0, "R1 duration");
    check(irq == 1'b0, "R1 irq", irq, 0);

    // R2/R3 disabled range check ignores a violated limit
    wr(5'h18, 200); wr(5'h08, 10); wr(5'h0C, 0);
    measure(32'h0, "R2 R3 range off", 48, 52, 3'b000);
    // R3 within limits
    wr(5'h08, 60); wr(5'h0C, 40);
    measure(32'h2, "R3 in range", 48, 52, 3'b000);
    // R3 over
    wr(5'h08, 30);
    measure(32'h2, "R3 over", 48, 52, 3'b001);
    check(irq == 1'b0, "R6 irq masked", irq, 0);
    wr(5'h00, 32'h12);
    @(negedge clk); check(irq == 1'b1, "R6 irq enabled", irq, 1);
    wr(5'h10, 32'h0);
    rd_chk(5'h10, 1, "R7 write zero keeps flag");
    wr(5'h10, 32'h1);
    rd_chk(5'h10, 0, "R7 write one clears");
    check(irq == 1'b0, "R6 irq after clear", irq, 0);
    // R3 under
    wr(5'h08, 100); wr(5'h0C, 70);
    measure(32'h2, "R3 under", 48, 52, 3'b010);
    // R4 minimum check
    measure(32'h0032_0004, "R4 below min", 48, 52, 3'b100);
    measure(32'h0014_0004, "R4 above min", 48, 52, 3'b000);
    // R5 period mode, no flags even with limits violated
    wr(5'h18, 10); wr(5'h08, 5);
    measure(32'h0063_000E, "R5 period", 44, 52, 3'b000);

    // R8 reserved and display
    rd(5'h04, keep);
    wr(5'h14, 32'hFFFF_FFFF);
    rd_chk(5'h14, 0, "R8 reserved reads zero");
    wr(5'h04, 32'hABCD);
    rd_chk(5'h04, keep, "R8 display read-only");

    // R9 soft lock
    wr(5'h00, 32'h102);
    rd_chk(5'h00, 32'h102, "R9 lock set");
    wr(5'h00, 32'h106);
    rd_chk(5'h00, 32'h102, "R9 locked write dropped");
    wr(5'h08, 32'h1234);
    rd_chk(5'h08, 32'h1234, "R9 other register writable");
    wr(5'h00, 32'h0);
    rd_chk(5'h00, 32'h002, "R9 unlock only lock bits");
    wr(5'h00, 32'h4);
    rd_chk(5'h00, 32'h004, "R9 write after unlock");

    // R10 hard lock
    wr(5'h00, 32'h304);
    rd_chk(5'h00, 32'h304, "R10 hard set");
    wr(5'h00, 32'h0);
    rd_chk(5'h00, 32'h304, "R10 release refused");
    wr(5'h00, 32'h305);
    rd_chk(5'h00, 32'h304, "R10 start dropped");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_chk(5'h00, 0, "R10 reset clears lock");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule